// File: doc/BRIEF.md
# Burst Column Address Generator

This block turns a single start request into the stream of column addresses that a synchronous DRAM burst walks through. A start strobe captures a starting column, a length code and an ordering choice. From the next clock on, the block presents one column per clock until the burst runs out, a stop request cuts it short, or a new start takes its place.

Two orderings are available. Sequential ordering counts upward and wraps inside the aligned block whose size is the burst length. Interleaved ordering XORs the low start bits with a beat count. A full-page length, legal only with sequential ordering, counts through every column of the row and keeps wrapping until it is stopped. A busy flag marks the clocks that carry a valid column, and a last flag marks the final beat of a finite burst. Row, bank and data handling belong to neighbouring blocks.

Top module: `burst_col_gen`

## Requirements
- R1: After reset, busy_o and last_o are 0 and col_o is 0.
- R2: On the clock after the edge that samples start_i high, busy_o is 1 and col_o equals the captured start column; after that one new column appears on every clock while the burst runs.
- R3: With seq_n_il_i=0 (sequential) and burst length BL, beat i shows the start's upper bits unchanged and the low log2(BL) bits equal to (start + i) mod BL.
- R4: With seq_n_il_i=1 (interleaved) and burst length BL, beat i shows the start's upper bits unchanged and the low log2(BL) bits equal to the start's low bits XOR i.
- R5: Length code len_i: 0 gives 1 beat, 1 gives 2, 2 gives 4, 3 gives 8, 7 gives full page; the reserved codes 4, 5 and 6 give a single beat.
- R6: For a finite burst, last_o is 1 on the final beat only, and busy_o is 0 on the clock after it unless a new start was sampled on that edge.
- R7: A full-page burst (code 7, sequential) advances the column by one modulo 512 on every clock, keeps running past 512 beats, and never raises last_o.
- R8: Code 7 with interleaved ordering is an error request: it yields one beat at the start column with last_o set, then the block goes idle.
- R9: A stop_i sampled high ends the burst at once: busy_o is 0 on the following clock.
- R10: A start_i sampled high replaces any running burst on any cycle, and takes precedence over a stop_i sampled on the same edge.
- R11: Whenever busy_o is 0, col_o is 0 and last_o is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin a new burst with the inputs below |
| start_col_i | input | 9 | Starting column |
| len_i | input | 3 | Burst length code |
| seq_n_il_i | input | 1 | 0 sequential ordering, 1 interleaved ordering |
| stop_i | input | 1 | Terminate the running burst |
| col_o | output | 9 | Current column address |
| busy_o | output | 1 | A valid column is being presented |
| last_o | output | 1 | Current beat is the final one of a finite burst |

## Verification
The checker watches on every clock the relations between the control inputs and the flags: that a start always produces a busy beat carrying the captured column, that stop or a last beat without a new start drops busy, that a running beat which is neither last nor interrupted is followed by another, and that the idle outputs stay at zero. The actual column orderings (sequential wrap inside the aligned block, the interleaved XOR pattern, the full-page wrap past column 511) and the length-code decoding including the reserved codes and the interleaved full-page error are shown only by the bench's directed scenarios, which compare every beat against sequences computed from the requirements.

// File: rtl/bcg_pkg.sv
package bcg_pkg;

   // Length codes; the numeric values are part of the port contract.
   typedef enum logic [2:0] {
      LEN_ONE   = 3'd0,
      LEN_TWO   = 3'd1,
      LEN_FOUR  = 3'd2,
      LEN_EIGHT = 3'd3,
      LEN_RSV4  = 3'd4,
      LEN_RSV5  = 3'd5,
      LEN_RSV6  = 3'd6,
      LEN_PAGE  = 3'd7
   } len_code_t;

   typedef enum logic {
      ORD_SEQ = 1'b0,
      ORD_IL  = 1'b1
   } order_t;

endpackage

// File: rtl/bcg_len_decode.sv
module bcg_len_decode
   import bcg_pkg::*;
#(
   parameter int COL_W = 9
)(
   input  logic [2:0]       len_i,
   input  logic             il_i,
   output logic [COL_W-1:0] wrap_mask_o,
   output logic [COL_W-1:0] last_idx_o,
   output logic             page_o
);

   localparam logic [COL_W-1:0] ALL_ONES = {COL_W{1'b1}};

   len_code_t code;
   assign code = len_code_t'(len_i);

   always_comb begin
      wrap_mask_o = '0;
      last_idx_o  = '0;
      page_o      = 1'b0;
      unique case (code)
         LEN_TWO:   begin wrap_mask_o = COL_W'(1); last_idx_o = COL_W'(1); end
         LEN_FOUR:  begin wrap_mask_o = COL_W'(3); last_idx_o = COL_W'(3); end
         LEN_EIGHT: begin wrap_mask_o = COL_W'(7); last_idx_o = COL_W'(7); end
         LEN_PAGE: begin
            if (il_i == ORD_SEQ) begin
               wrap_mask_o = ALL_ONES;
               last_idx_o  = ALL_ONES;
               page_o      = 1'b1;
            end
            // interleaved full page is an error: single beat (mask 0, last 0)
         end
         default: begin
            // one beat: LEN_ONE and the reserved codes
         end
      endcase
   end

endmodule

// File: rtl/bcg_burst_ctl.sv
module bcg_burst_ctl #(
   parameter int COL_W = 9
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic [COL_W-1:0] start_col_i,
   input  logic             il_i,
   input  logic [COL_W-1:0] wrap_mask_i,
   input  logic [COL_W-1:0] last_idx_i,
   input  logic             page_i,
   input  logic             stop_i,
   output logic [COL_W-1:0] base_o,
   output logic [COL_W-1:0] mask_o,
   output logic [COL_W-1:0] beat_o,
   output logic             il_o,
   output logic             busy_o,
   output logic             last_o
);

   logic [COL_W-1:0] base_q, mask_q, beat_q, lidx_q;
   logic             il_q, page_q, busy_q;
   logic             at_end;

   assign at_end = busy_q && !page_q && (beat_q == lidx_q);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         base_q <= '0;
         mask_q <= '0;
         beat_q <= '0;
         lidx_q <= '0;
         il_q   <= 1'b0;
         page_q <= 1'b0;
         busy_q <= 1'b0;
      end else if (start_i) begin
         base_q <= start_col_i;
         mask_q <= wrap_mask_i;
         lidx_q <= last_idx_i;
         il_q   <= il_i;
         page_q <= page_i;
         beat_q <= '0;
         busy_q <= 1'b1;
      end else if (stop_i || at_end) begin
         busy_q <= 1'b0;
         beat_q <= '0;
      end else if (busy_q) begin
         beat_q <= beat_q + COL_W'(1);
      end
   end

   assign base_o = base_q;
   assign mask_o = mask_q;
   assign beat_o = beat_q;
   assign il_o   = il_q;
   assign busy_o = busy_q;
   assign last_o = at_end;

endmodule

// File: rtl/bcg_addr_map.sv
module bcg_addr_map #(
   parameter int COL_W = 9
)(
   input  logic [COL_W-1:0] base_i,
   input  logic [COL_W-1:0] mask_i,
   input  logic [COL_W-1:0] beat_i,
   input  logic             il_i,
   input  logic             busy_i,
   output logic [COL_W-1:0] col_o
);

   logic [COL_W-1:0] seq_v, il_v, pick;

   assign seq_v = base_i + beat_i;
   assign il_v  = base_i ^ beat_i;

   // Per-bit select: wrapping bits follow the ordering, others hold the start.
   for (genvar b = 0; b < COL_W; b++) begin : g_bit
      always_comb begin
         if (!mask_i[b])
            pick[b] = base_i[b];
         else if (il_i)
            pick[b] = il_v[b];
         else
            pick[b] = seq_v[b];
      end
   end

   assign col_o = busy_i ? pick : '0;

endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen #(
   parameter int COL_W = 9
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic [COL_W-1:0] start_col_i,
   input  logic [2:0]       len_i,
   input  logic             seq_n_il_i,
   input  logic             stop_i,
   output logic [COL_W-1:0] col_o,
   output logic             busy_o,
   output logic             last_o
);

   localparam int MAX_FIN_BL = 8;

   if (COL_W < $clog2(MAX_FIN_BL) + 1) begin : g_width_chk
      $error("COL_W too small for the longest finite burst");
   end

   logic [COL_W-1:0] dec_mask, dec_lidx;
   logic             dec_page;
   logic [COL_W-1:0] st_base, st_mask, st_beat;
   logic             st_il;

   bcg_len_decode #(.COL_W(COL_W)) u_dec (
      .len_i      (len_i),
      .il_i       (seq_n_il_i),
      .wrap_mask_o(dec_mask),
      .last_idx_o (dec_lidx),
      .page_o     (dec_page)
   );

   bcg_burst_ctl #(.COL_W(COL_W)) u_ctl (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_i    (start_i),
      .start_col_i(start_col_i),
      .il_i       (seq_n_il_i),
      .wrap_mask_i(dec_mask),
      .last_idx_i (dec_lidx),
      .page_i     (dec_page),
      .stop_i     (stop_i),
      .base_o     (st_base),
      .mask_o     (st_mask),
      .beat_o     (st_beat),
      .il_o       (st_il),
      .busy_o     (busy_o),
      .last_o     (last_o)
   );

   bcg_addr_map #(.COL_W(COL_W)) u_map (
      .base_i(st_base),
      .mask_i(st_mask),
      .beat_i(st_beat),
      .il_i  (st_il),
      .busy_i(busy_o),
      .col_o (col_o)
   );

endmodule

// File: rtl/burst_col_gen_chk.sv
module burst_col_gen_chk #(
   parameter int COL_W = 9
)(
   input logic             clk,
   input logic             rst_n,
   input logic             start_i,
   input logic [COL_W-1:0] start_col_i,
   input logic             stop_i,
   input logic [COL_W-1:0] col_o,
   input logic             busy_o,
   input logic             last_o
);

   assert_start_loads_R10: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |=> (busy_o && col_o == $past(start_col_i)));

   assert_stop_ends_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (stop_i && !start_i) |=> !busy_o);

   assert_last_ends_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (last_o && !start_i) |=> !busy_o);

   assert_beat_continues_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && !last_o && !start_i && !stop_i) |=> busy_o);

   assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> (col_o == '0 && !last_o));

endmodule

bind burst_col_gen burst_col_gen_chk #(.COL_W(COL_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .start_i    (start_i),
   .start_col_i(start_col_i),
   .stop_i     (stop_i),
   .col_o      (col_o),
   .busy_o     (busy_o),
   .last_o     (last_o)
);

// File: tb/burst_col_gen_tb_top.sv
module burst_col_gen_tb_top;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start_i = 1'b0;
   logic [8:0] start_col_i = '0;
   logic [2:0] len_i = '0;
   logic       seq_n_il_i = 1'b0;
   logic       stop_i = 1'b0;
   logic [8:0] col_o;
   logic       busy_o, last_o;

   int checks = 0;
   int fails  = 0;
   int cycles = 0;

   always #10 clk = ~clk;   // 50 MHz

   burst_col_gen dut_i (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_col_i(start_col_i),
      .len_i(len_i), .seq_n_il_i(seq_n_il_i), .stop_i(stop_i),
      .col_o(col_o), .busy_o(busy_o), .last_o(last_o)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // expected column for beat i from the requirements
   function automatic logic [8:0] exp_col(input logic [8:0] c, input int bl,
                                          input bit il, input int i);
      logic [8:0] m;
      if (bl == 512) return 9'(c + 9'(i));
      m = 9'(bl - 1);
      if (il) return (c & ~m) | ((c ^ 9'(i)) & m);
      return (c & ~m) | (9'(c + 9'(i)) & m);
   endfunction

   // pulse start at a negedge; returns at the negedge that shows beat 0
   task automatic launch(input logic [8:0] c, input logic [2:0] code, input bit il);
      start_col_i = c; len_i = code; seq_n_il_i = il; start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
   endtask

   task automatic run_full(input logic [8:0] c, input logic [2:0] code, input bit il,
                           input int bl, input string req);
      @(negedge clk);
      launch(c, code, il);
      for (int i = 0; i < bl; i++) begin
         chk(busy_o == 1'b1, {req, " busy"}, int'(busy_o), 1);
         chk(col_o == exp_col(c, bl, il, i), req, int'(col_o), int'(exp_col(c, bl, il, i)));
         chk(last_o == (i == bl - 1), {req, " R6 last"}, int'(last_o), int'(i == bl - 1));
         @(negedge clk);
      end
      chk(busy_o == 1'b0, {req, " R6 idle after"}, int'(busy_o), 0);
      chk(col_o == 9'd0, {req, " R11 col idle"}, int'(col_o), 0);
   endtask

   task automatic t_reset();
      chk(busy_o == 1'b0, "R1 busy", int'(busy_o), 0);
      chk(last_o == 1'b0, "R1 last", int'(last_o), 0);
      chk(col_o == 9'd0, "R1 col", int'(col_o), 0);
   endtask

   task automatic t_sequential();
      run_full(9'h1FD, 3'd3, 1'b0, 8, "R3 R2 seq8");
      run_full(9'h0A6, 3'd2, 1'b0, 4, "R3 seq4");
      run_full(9'h0FF, 3'd1, 1'b0, 2, "R3 seq2");
      run_full(9'h123, 3'd0, 1'b0, 1, "R5 len1");
   endtask

   task automatic t_interleave();
      run_full(9'h0A6, 3'd2, 1'b1, 4, "R4 il4");
      run_full(9'h013, 3'd3, 1'b1, 8, "R4 il8");
      run_full(9'h155, 3'd1, 1'b1, 2, "R4 il2");
   endtask

   task automatic t_reserved();
      run_full(9'h0C4, 3'd4, 1'b0, 1, "R5 rsv4");
      run_full(9'h0C5, 3'd5, 1'b1, 1, "R5 rsv5");
      run_full(9'h0C6, 3'd6, 1'b0, 1, "R5 rsv6");
   endtask

   task automatic t_page_error();
      run_full(9'h077, 3'd7, 1'b1, 1, "R8 il page");
   endtask

   task automatic t_full_page();
      bit saw_last = 1'b0;
      bit bad_col  = 1'b0;
      logic [8:0] c = 9'h1FE;
      @(negedge clk);
      launch(c, 3'd7, 1'b0);
      for (int i = 0; i < 520; i++) begin
         if (last_o) saw_last = 1'b1;
         if (!busy_o || col_o != 9'(c + 9'(i))) bad_col = 1'b1;
         if (i == 2) chk(col_o == 9'h000, "R7 wrap to 0", int'(col_o), 0);
         if (i == 513) chk(col_o == 9'h1FF, "R7 second lap", int'(col_o), 9'h1FF);
         if (i == 519) stop_i = 1'b1;
         @(negedge clk);
      end
      stop_i = 1'b0;
      chk(!bad_col, "R7 page sequence", int'(bad_col), 0);
      chk(!saw_last, "R7 no last", int'(saw_last), 0);
      chk(busy_o == 1'b0, "R9 stop page", int'(busy_o), 0);
   endtask

   task automatic t_stop();
      @(negedge clk);
      launch(9'h020, 3'd3, 1'b0);
      @(negedge clk);
      @(negedge clk);
      chk(col_o == 9'h022, "R9 before stop", int'(col_o), 9'h022);
      stop_i = 1'b1;
      @(negedge clk);
      stop_i = 1'b0;
      chk(busy_o == 1'b0, "R9 stopped", int'(busy_o), 0);
      chk(col_o == 9'h000, "R9 R11 col zero", int'(col_o), 0);
      @(negedge clk);
      chk(busy_o == 1'b0, "R9 stays idle", int'(busy_o), 0);
   endtask

   task automatic t_restart();
      @(negedge clk);
      launch(9'h040, 3'd3, 1'b0);
      @(negedge clk);
      @(negedge clk);
      @(negedge clk);
      chk(col_o == 9'h043, "R10 old beat3", int'(col_o), 9'h043);
      start_col_i = 9'h105; len_i = 3'd2; seq_n_il_i = 1'b0; start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      for (int i = 0; i < 4; i++) begin
         chk(col_o == exp_col(9'h105, 4, 1'b0, i), "R10 new burst", int'(col_o),
             int'(exp_col(9'h105, 4, 1'b0, i)));
         chk(last_o == (i == 3), "R10 R6 last", int'(last_o), int'(i == 3));
         @(negedge clk);
      end
      chk(busy_o == 1'b0, "R10 end", int'(busy_o), 0);
      // start and stop together: start wins
      launch(9'h030, 3'd1, 1'b0);
      stop_i = 1'b1; start_col_i = 9'h0E1; len_i = 3'd1; start_i = 1'b1;
      @(negedge clk);
      stop_i = 1'b0; start_i = 1'b0;
      chk(busy_o == 1'b1, "R10 start beats stop", int'(busy_o), 1);
      chk(col_o == 9'h0E1, "R10 start beats stop col", int'(col_o), 9'h0E1);
      @(negedge clk);
      chk(col_o == 9'h0E0, "R10 R3 second beat", int'(col_o), 9'h0E0);
      chk(last_o == 1'b1, "R10 R6 last", int'(last_o), 1);
      @(negedge clk);
      chk(busy_o == 1'b0, "R10 idle", int'(busy_o), 0);
   endtask

   // last beat followed directly by a new start keeps busy high
   task automatic t_back_to_back();
      @(negedge clk);
      launch(9'h010, 3'd1, 1'b0);
      @(negedge clk);
      chk(last_o == 1'b1, "R6 last before chain", int'(last_o), 1);
      start_col_i = 9'h1A0; len_i = 3'd0; start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      chk(busy_o == 1'b1 && col_o == 9'h1A0, "R6 R2 chained start", int'(col_o), 9'h1A0);
      @(negedge clk);
      chk(busy_o == 1'b0, "R6 chain done", int'(busy_o), 0);
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000) begin
         fails++;
         $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_sequential();
      t_interleave();
      t_reserved();
      t_page_error();
      t_full_page();
      t_stop();
      t_restart();
      t_back_to_back();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule